// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Glitch Rejection

This block receives asynchronous serial characters from one RX line. A separate baud generator supplies a 16x oversampling tick, and the receiver samples the line once on each tick. The line rests high. A falling edge starts a qualification window of sixteen samples. The start bit is accepted only when enough of those samples are low. A shorter low pulse is treated as line noise: the receiver returns to rest and raises a one-cycle noise strobe.

Once a start bit is accepted, the receiver collects eight data bits, least significant first. After them come an optional parity bit and one or two stop bits, chosen by static configuration inputs. Each bit is settled by a two-of-three vote over the samples in the middle of its period. Edges elsewhere in the bit have no effect. Each completed character is presented as a registered byte with a one-cycle valid strobe and three condition flags: parity mismatch, framing fault and line break. After a break, the receiver ignores the line until it has returned high.

The RX input is brought into the clock domain by a short synchronizer chain. Buffering of received bytes and generation of the tick are left to the surrounding logic.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_noise`, `rx_byte`, `rx_par_err`, `rx_frm_err` and `rx_break` are all 0. While the line stays high, no valid or noise strobe appears.
- R2: Sample phase 0 of a start bit is the first low sample taken on a tick after a high sample. The start bit is accepted when at least 8 of the 16 samples at phases 0 to 15 are low. Exactly 8 low samples is accepted.
- R3: If fewer than 8 of those 16 samples are low, no character is produced. Instead `rx_noise` is high for one clock, in the cycle after the tick that carries phase 15.
- R4: Each bit after the start bit lasts 16 ticks, counted from phase 0. Its value is the majority of the samples at phases 7, 8 and 9. A single disagreeing sample at phase 8 is outvoted. Disagreeing samples at both 7 and 8 decide the bit.
- R5: Eight data bits follow the start bit, least significant first. Transitions at phases 0 to 3 and 12 to 15 of a bit do not change the received value.
- R6: When `cfg_par_en` is 1, one parity bit follows the data. Under even parity (`cfg_par_odd`=0) the expected parity bit is the XOR of the 8 data bits; odd parity expects its inverse. `rx_par_err` is 1 exactly when the received parity bit differs from the expected one. With parity disabled, `rx_par_err` is 0.
- R7: `cfg_two_stop` selects one stop bit (0) or two (1). `rx_frm_err` is 1 when any stop bit is voted low.
- R8: When every data bit, the parity bit (if enabled) and every stop bit is voted low, `rx_break` and `rx_frm_err` are 1 and `rx_byte` is 0. No new start bit is then searched for until a high sample has been seen.
- R9: `rx_valid` is a one-clock strobe in the cycle after the tick that carries phase 9 of the last stop bit. `rx_byte` and the flags change only with that strobe.
- R10: The line is sampled only on tick cycles. A low pulse on the RX input that is gone by the last two clock edges before a tick does not affect reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-clock strobe at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, rests high |
| cfg_par_en | input | 1 | 1 = a parity bit follows the data |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| rx_byte | output | 8 | Last received character |
| rx_valid | output | 1 | One-clock strobe: new character and flags |
| rx_par_err | output | 1 | Parity mismatch of the last character |
| rx_frm_err | output | 1 | A stop bit of the last character was low |
| rx_break | output | 1 | The last character was an all-low break |
| rx_noise | output | 1 | One-clock strobe: rejected start glitch |

## Verification
The line value must be driven at least two clock edges before a tick so that it passes the synchronizer. The bench drives a new sample right after a tick and raises the tick on the fourth clock of each sample period. A noise strobe is due in the clock after the tick that carries the 16th start sample. A character strobe is due in the clock after the tick that carries phase 9 of the final stop bit. The bench places each expected event at the tick index of that sample in its stimulus queue, and on every falling clock edge compares both strobes with the pending events, together with the byte and flags whenever a character is due.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= din;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_vote3.sv
module uart_rx_vote3 #(
  parameter int PH_W     = 4,
  parameter int VOTE_MID = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            sample,
  input  logic [PH_W-1:0] phase,
  output logic            bit_val
);
  localparam logic [PH_W-1:0] PH_EARLY = PH_W'(VOTE_MID - 1);
  localparam logic [PH_W-1:0] PH_MID   = PH_W'(VOTE_MID);

  logic s_early, s_mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_early <= 1'b1;
      s_mid   <= 1'b1;
    end else if (tick) begin
      if (phase == PH_EARLY) s_early <= sample;
      if (phase == PH_MID)   s_mid   <= sample;
    end
  end

  // valid on the tick carrying phase VOTE_MID+1
  assign bit_val = (s_early & s_mid) | (s_early & sample) | (s_mid & sample);
endmodule

// File: rtl/uart_rx_start_qual.sv
module uart_rx_start_qual #(
  parameter int OSR       = 16,
  parameter int START_MIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sample,
  input  logic arm,
  input  logic run,
  output logic qual_ok
);
  localparam int CW = $clog2(OSR + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (arm) low_cnt <= CW'(1);
    else if (run && tick && !sample) low_cnt <= low_cnt + CW'(1);
  end

  assign qual_ok = (int'(low_cnt) + int'(!sample)) >= START_MIN;

  AST_LOWCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(low_cnt) <= OSR); // R2
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int VOTE_MID    = 8,
  parameter int START_MIN   = 8,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 os_tick,
  input  logic                 rx_line,
  input  logic                 cfg_par_en,
  input  logic                 cfg_par_odd,
  input  logic                 cfg_two_stop,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 rx_par_err,
  output logic                 rx_frm_err,
  output logic                 rx_break,
  output logic                 rx_noise
);
  localparam int PH_W = $clog2(OSR);
  localparam int BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [PH_W-1:0] PH_VOTE = PH_W'(VOTE_MID + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam logic [BW-1:0]   BIT_LAST = BW'(DATA_BITS - 1);

  rx_state_e            state;
  logic [PH_W-1:0]      ph;
  logic [BW-1:0]        bidx;
  logic                 stop_idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_bit, frm_acc, all_low, prev_s;
  logic                 samp, vote, qual_ok, arm, par_exp;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_line), .dout(samp)
  );

  uart_rx_vote3 #(.PH_W(PH_W), .VOTE_MID(VOTE_MID)) u_vote (
    .clk(clk), .rst(rst), .tick(os_tick), .sample(samp), .phase(ph),
    .bit_val(vote)
  );

  assign arm = os_tick && (state == ST_IDLE) && prev_s && !samp;

  uart_rx_start_qual #(.OSR(OSR), .START_MIN(START_MIN)) u_qual (
    .clk(clk), .rst(rst), .tick(os_tick), .sample(samp), .arm(arm),
    .run(state == ST_START), .qual_ok(qual_ok)
  );

  assign par_exp = cfg_par_odd ? ~^shreg : ^shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ph         <= '0;
      bidx       <= '0;
      stop_idx   <= 1'b0;
      shreg      <= '0;
      par_bit    <= 1'b0;
      frm_acc    <= 1'b0;
      all_low    <= 1'b0;
      prev_s     <= 1'b1;
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      rx_break   <= 1'b0;
      rx_noise   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_noise <= 1'b0;
      if (os_tick) begin
        prev_s <= samp;
        unique case (state)
          ST_IDLE: begin
            if (prev_s && !samp) begin
              state <= ST_START;
              ph    <= PH_W'(1);
            end
          end
          ST_START: begin
            if (ph == PH_LAST) begin
              ph <= '0;
              if (qual_ok) begin
                state    <= ST_DATA;
                bidx     <= '0;
                all_low  <= 1'b1;
                frm_acc  <= 1'b0;
                stop_idx <= 1'b0;
              end else begin
                state    <= ST_IDLE;
                rx_noise <= 1'b1;
              end
            end else ph <= ph + PH_W'(1);
          end
          ST_DATA: begin
            if (ph == PH_VOTE) begin
              shreg   <= {vote, shreg[DATA_BITS-1:1]};
              all_low <= all_low & !vote;
            end
            if (ph == PH_LAST) begin
              ph <= '0;
              if (bidx == BIT_LAST) state <= cfg_par_en ? ST_PAR : ST_STOP;
              else bidx <= bidx + BW'(1);
            end else ph <= ph + PH_W'(1);
          end
          ST_PAR: begin
            if (ph == PH_VOTE) begin
              par_bit <= vote;
              all_low <= all_low & !vote;
            end
            if (ph == PH_LAST) begin
              ph    <= '0;
              state <= ST_STOP;
            end else ph <= ph + PH_W'(1);
          end
          ST_STOP: begin
            if (ph == PH_VOTE && stop_idx == cfg_two_stop) begin
              rx_valid   <= 1'b1;
              rx_byte    <= shreg;
              rx_par_err <= cfg_par_en && (par_bit != par_exp);
              rx_frm_err <= frm_acc | !vote;
              rx_break   <= all_low & !vote;
              state      <= (all_low & !vote) ? ST_HOLD : ST_IDLE;
              ph         <= '0;
            end else begin
              if (ph == PH_VOTE) begin
                frm_acc <= frm_acc | !vote;
                all_low <= all_low & !vote;
              end
              if (ph == PH_LAST) begin
                ph       <= '0;
                stop_idx <= 1'b1;
              end else ph <= ph + PH_W'(1);
            end
          end
          ST_HOLD: if (samp) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_VALID_STROBE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R9
  AST_NOISE_ALONE: assert property (@(posedge clk) disable iff (rst)
    rx_noise |-> !rx_valid); // R3
  AST_BREAK_FRAMES: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_break) |-> (rx_frm_err && rx_byte == '0)); // R8
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && os_tick && !samp) |=> state == ST_HOLD); // R8
  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
    !os_tick |=> ($stable(state) && $stable(ph))); // R10
  AST_PAR_GATED: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !cfg_par_en) |-> !rx_par_err); // R6
endmodule

// File: tb/uart_os_rx_test.sv
module uart_os_rx_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b0, rx_line = 1'b1;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic [7:0] rx_byte;
  logic rx_valid, rx_par_err, rx_frm_err, rx_break, rx_noise;

  always #5 clk = ~clk;

  uart_os_rx uut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_break(rx_break),
    .rx_noise(rx_noise)
  );

  int errors = 0, checks = 0;
  bit done = 0, run_chk = 0;

  // stimulus: one entry per tick
  bit q_rx[$], q_pulse[$], q_pen[$], q_podd[$], q_two[$];
  bit g_pen = 0, g_podd = 0, g_two = 0;
  // expected events by tick index: 1 = character, 2 = noise
  int         ev_kind[int];
  logic [7:0] ev_data[int];
  bit         ev_pe[int], ev_fe[int], ev_brk[int];
  string      ev_req[int];

  int cur_k = -1, k_d = -1;
  bit tick_d = 0;

  task automatic push(input bit v, input bit pulse);
    q_rx.push_back(v); q_pulse.push_back(pulse);
    q_pen.push_back(g_pen); q_podd.push_back(g_podd); q_two.push_back(g_two);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) push(1'b1, 1'b0);
  endtask

  // mode 0 clean, 1 edge-region flips, 2 phase-8 flip, 3 bit0 phases 7+8 flipped,
  // 4 between-tick low pulses on every high sample
  task automatic add_frame(input logic [7:0] d, input bit flip_par,
                           input bit stop_low, input int mode, input string req);
    int s; bit v; bit p; logic [7:0] got; int last;
    s = q_rx.size();
    for (int i = 0; i < 16; i++) push(1'b0, 1'b0);
    got = d;
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < 16; i++) begin
        v = d[b];
        if (mode == 1 && (i < 4 || i > 11)) v = ~v;
        if (mode == 2 && i == 8) v = ~v;
        if (mode == 3 && b == 0 && (i == 7 || i == 8)) v = ~v;
        push(v, mode == 4 && v);
      end
    end
    if (mode == 3) got[0] = ~got[0];
    p = g_podd ? ~^d : ^d;
    p = p ^ flip_par;
    if (g_pen) for (int i = 0; i < 16; i++) push(p, 1'b0);
    for (int i = 0; i < 16; i++) push(!stop_low, 1'b0);
    if (g_two) for (int i = 0; i < 16; i++) push(1'b1, 1'b0);
    last = 9 + int'(g_pen) + int'(g_two);
    ev_kind[s + 16*last + 9] = 1;
    ev_data[s + 16*last + 9] = got;
    ev_pe[s + 16*last + 9]   = g_pen && (p != (g_podd ? ~^got : ^got));
    ev_fe[s + 16*last + 9]   = stop_low;
    ev_brk[s + 16*last + 9]  = 0;
    ev_req[s + 16*last + 9]  = req;
    idle(20);
  endtask

  task automatic add_glitch(input int nlow, input string req);
    int s;
    s = q_rx.size();
    for (int i = 0; i < nlow; i++) push(1'b0, 1'b0);
    if (nlow < 8) begin
      ev_kind[s + 15] = 2; ev_req[s + 15] = req;
      idle(40);
    end else begin
      // accepted start: the line is high afterwards, so the data reads all ones
      ev_kind[s + 16*(9 + int'(g_pen) + int'(g_two)) + 9] = 1;
      ev_data[s + 16*(9 + int'(g_pen) + int'(g_two)) + 9] = 8'hFF;
      ev_pe[s + 16*(9 + int'(g_pen) + int'(g_two)) + 9]   = 0;
      ev_fe[s + 16*(9 + int'(g_pen) + int'(g_two)) + 9]   = 0;
      ev_brk[s + 16*(9 + int'(g_pen) + int'(g_two)) + 9]  = 0;
      ev_req[s + 16*(9 + int'(g_pen) + int'(g_two)) + 9]  = req;
      idle(16*(11 + int'(g_two)) + 20 - nlow);
    end
  endtask

  task automatic add_break(input int extra, input string req);
    int s; int last;
    s = q_rx.size();
    last = 9 + int'(g_pen) + int'(g_two);
    for (int i = 0; i < 16*(last+1) + extra; i++) push(1'b0, 1'b0);
    ev_kind[s + 16*last + 9] = 1;
    ev_data[s + 16*last + 9] = 8'h00;
    ev_pe[s + 16*last + 9]   = g_pen && g_podd;
    ev_fe[s + 16*last + 9]   = 1;
    ev_brk[s + 16*last + 9]  = 1;
    ev_req[s + 16*last + 9]  = req;
    idle(20);
  endtask

  always @(posedge clk) begin
    tick_d <= os_tick;
    k_d    <= cur_k;
  end

  // per-clock comparison against the expected event list
  always @(negedge clk) begin
    if (run_chk) begin
      bit ev_v, ev_n; string rq;
      ev_v = tick_d && ev_kind.exists(k_d) && ev_kind[k_d] == 1;
      ev_n = tick_d && ev_kind.exists(k_d) && ev_kind[k_d] == 2;
      rq = (tick_d && ev_req.exists(k_d)) ? ev_req[k_d] : "R1/R10 no spurious strobe";
      checks++;
      if (rx_valid !== ev_v) begin
        errors++;
        $display("FAIL %s: rx_valid=%0b expected %0b (tick %0d)", rq, rx_valid, ev_v, k_d);
      end
      checks++;
      if (rx_noise !== ev_n) begin
        errors++;
        $display("FAIL %s: rx_noise=%0b expected %0b (tick %0d)", rq, rx_noise, ev_n, k_d);
      end
      if (ev_v) begin
        checks++;
        if (rx_byte !== ev_data[k_d] || rx_par_err !== ev_pe[k_d] ||
            rx_frm_err !== ev_fe[k_d] || rx_break !== ev_brk[k_d]) begin
          errors++;
          $display("FAIL %s: byte=%02h pe=%0b fe=%0b brk=%0b expected byte=%02h pe=%0b fe=%0b brk=%0b",
                   rq, rx_byte, rx_par_err, rx_frm_err, rx_break,
                   ev_data[k_d], ev_pe[k_d], ev_fe[k_d], ev_brk[k_d]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // build the stimulus
    idle(24);
    add_frame(8'hA5, 0, 0, 0, "R5 LSB-first 8N1 / R9 timing");
    g_pen = 1; g_podd = 0;
    add_frame(8'h3C, 0, 0, 0, "R6 even parity ok");
    add_frame(8'h3C, 1, 0, 0, "R6 even parity error");
    g_podd = 1; g_two = 1;
    add_frame(8'h81, 0, 0, 0, "R6 odd parity / R7 two stops");
    add_frame(8'h81, 0, 1, 0, "R7 first of two stops low");
    g_pen = 0; g_two = 0;
    add_frame(8'h42, 0, 1, 0, "R7 single stop low");
    add_frame(8'h5A, 0, 0, 1, "R5 edge-region transitions ignored");
    add_frame(8'h96, 0, 0, 2, "R4 phase 8 outvoted");
    add_frame(8'h96, 0, 0, 3, "R4 phases 7 and 8 decide");
    add_glitch(3, "R3 short glitch noise");
    add_glitch(7, "R3 seven lows rejected");
    add_glitch(8, "R2 eight lows accepted");
    add_frame(8'hC3, 0, 0, 4, "R10 between-tick pulses ignored");
    add_break(40, "R8 break one stop");
    add_frame(8'h7E, 0, 0, 0, "R8 character after break");
    g_pen = 1; g_podd = 1; g_two = 1;
    add_break(30, "R8 break odd parity two stops");
    add_frame(8'h11, 0, 0, 0, "R8 R6 character after second break");

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rx_valid !== 0 || rx_noise !== 0 || rx_byte !== 8'h00 ||
        rx_par_err !== 0 || rx_frm_err !== 0 || rx_break !== 0) begin
      errors++;
      $display("FAIL R1 reset: valid=%0b noise=%0b byte=%02h pe=%0b fe=%0b brk=%0b expected all 0",
               rx_valid, rx_noise, rx_byte, rx_par_err, rx_frm_err, rx_break);
    end
    @(posedge clk); #1;
    run_chk = 1;
    for (int k = 0; k < q_rx.size(); k++) begin
      cfg_par_en = q_pen[k]; cfg_par_odd = q_podd[k]; cfg_two_stop = q_two[k];
      rx_line = q_pulse[k] ? 1'b0 : q_rx[k];
      os_tick = 1'b0; cur_k = k;
      @(posedge clk); #1 rx_line = q_rx[k];
      @(posedge clk); #1;
      @(posedge clk); #1 os_tick = 1'b1;
      @(posedge clk); #1 os_tick = 1'b0;
    end
    repeat (8) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule